// File: doc/BRIEF.md
# Host-Register to AXI4-Lite Master Bridge

This block lets a narrow host bus run single-beat 32-bit AXI4-Lite transactions. The host sees eight 16-bit registers. It loads a 32-bit target address and a 32-bit write value as low and high halves, then writes a command code to the control register. The bridge runs one AXI4-Lite write or read on its master port and records the outcome as an event flag: completion, slave error or watchdog timeout.

Each event flag is raised only when its enable bit is set. The interrupt line is the OR of the raised flags whose enables are still set. The host clears a flag by writing a 1 to it. For walking through a block of addresses, two of the command codes also step the address register by one word after a successful transfer.

Top module: `axlb_bridge`

## Requirements
- R1: After reset, offset 0 reads 0x0020, where bit 5 is the initialization-done flag. Offsets 1 to 7 read 0, `irq_o` is low and no AXI valid is driven.
- R2: Writing command 0x8 to the low nibble of offset 1 issues one AXI write. The address is {offset 3, offset 2}, the data is {offset 5, offset 4} and the strobe is 0xF. An OKAY response raises status bit 14.
- R3: Command 0xA issues one AXI read at {offset 3, offset 2}. On an OKAY response, data bits 15:0 go to offset 6 and bits 31:16 go to offset 7, and status bits 15 and 7 are raised. Bit 7 is cleared when the next command is accepted.
- R4: Control bits 15 to 11 enable status bits 15 to 11, which are read complete, write complete, timeout, error and AXI interrupt. An event whose enable is clear leaves its status bit at 0.
- R5: Status bits 15 to 11 are write-one-to-clear at offset 0. Writing 0 to such a bit leaves it set, and bits 7, 6 and 5 cannot be written.
- R6: Commands 0x9 and 0xB behave like 0x8 and 0xA. After an OKAY response they also add 4 to the 32-bit address, with the carry propagating from offset 2 into offset 3.
- R7: A response of 2 or 3 (SLVERR or DECERR) raises only status bit 12. Completion bits and bit 7 stay clear, and the read data and address registers keep their values.
- R8: If no response arrives within TMO_CYCLES active cycles, the bridge raises status bit 13, clears busy and drops every AXI valid and ready.
- R9: Status bit 6 (busy) is set from command acceptance until the transaction ends. While busy, command codes and writes to offsets 2 to 5 are ignored. The enable bits stay writable.
- R10: `irq_o` is the OR of status bits 15 to 11 ANDed with their enables. If bit 11 is enabled, a cycle with `axi_irq_i` high raises status bit 11.
- R11: Command 0x0 (NOP) and the codes outside 0x8 to 0xB start no transaction and leave the status unchanged.
- R12: Every transaction ends with exactly one outcome: completion, error or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 3 | Host register offset |
| hst_wdata | input | 16 | Host write data |
| hst_wr | input | 1 | Host write strobe |
| hst_rdata | output | 16 | Host read data for `hst_addr` (combinational) |
| axi_irq_i | input | 1 | Interrupt request from the AXI side |
| irq_o | output | 1 | Interrupt to the host |
| m_awaddr | output | 32 | AXI write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | AXI write data |
| m_wstrb | output | 4 | Write strobes, always all ones |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | AXI read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | AXI read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
If the transfer state machine is left in the wrong state, the busy bit stays set or never sets, and this shows in the first status read after the command. If the outcome is decoded wrongly, a different event bit is raised within one cycle of the response and `irq_o` changes with it. A faulty address stepper or read-data capture is seen on the next host read of offsets 2, 3, 6 and 7, and also as a wrong `m_awaddr` or `m_araddr` on the following transfer. A watchdog that never fires leaves busy set for good, so the bench checks busy both before and after the timeout window.

// File: rtl/axlb_pkg.sv
package axlb_pkg;

    localparam int HW   = 16;
    localparam int AW   = 32;
    localparam int RA_W = 3;
    localparam int NEV  = 5;

    localparam logic [RA_W-1:0] OFS_STAT = 3'd0;
    localparam logic [RA_W-1:0] OFS_CTRL = 3'd1;
    localparam logic [RA_W-1:0] OFS_ALO  = 3'd2;
    localparam logic [RA_W-1:0] OFS_AHI  = 3'd3;
    localparam logic [RA_W-1:0] OFS_WLO  = 3'd4;
    localparam logic [RA_W-1:0] OFS_WHI  = 3'd5;
    localparam logic [RA_W-1:0] OFS_RLO  = 3'd6;
    localparam logic [RA_W-1:0] OFS_RHI  = 3'd7;

    // event vector index; index i maps to register bit 11+i
    localparam int EV_IRQ = 0;
    localparam int EV_ERR = 1;
    localparam int EV_TMO = 2;
    localparam int EV_WR  = 3;
    localparam int EV_RD  = 4;

    localparam logic [AW-1:0] ADDR_STEP = 32'd4;

    typedef enum logic [1:0] {X_IDLE, X_WRITE, X_READ} xst_e;
    typedef enum logic [1:0] {RES_OK, RES_ERR, RES_TMO} res_e;

    typedef struct packed {
        logic          go;
        logic          is_read;
        logic [AW-1:0] addr;
        logic [AW-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic          valid;
        res_e          res;
        logic          is_read;
        logic [AW-1:0] rdata;
    } done_t;

    // codes 0x8..0xB start a transfer
    function automatic logic cmd_is_xfer(input logic [3:0] c);
        return c[3:2] == 2'b10;
    endfunction

    function automatic logic [HW-1:0] status_word(input logic [NEV-1:0] ev,
                                                  input logic avail,
                                                  input logic busy,
                                                  input logic init);
        return {ev, 3'b000, avail, busy, init, 5'b00000};
    endfunction

endpackage

// File: rtl/axlb_xfer.sv
module axlb_xfer
    import axlb_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  req_t          req,
    output done_t         done,
    output logic          busy,
    output logic [AW-1:0] awaddr,
    output logic          awvalid,
    input  logic          awready,
    output logic [AW-1:0] wdata,
    output logic [AW/8-1:0] wstrb,
    output logic          wvalid,
    input  logic          wready,
    input  logic [1:0]    bresp,
    input  logic          bvalid,
    output logic          bready,
    output logic [AW-1:0] araddr,
    output logic          arvalid,
    input  logic          arready,
    input  logic [AW-1:0] rdata,
    input  logic [1:0]    rresp,
    input  logic          rvalid,
    output logic          rready
);

    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

    xst_e          st;
    logic          aw_done, w_done, ar_done;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q, wdata_q;
    logic          resp_hit, tmo_hit;
    logic [1:0]    resp;

    always_comb begin
        resp_hit     = (st == X_WRITE && bvalid) || (st == X_READ && rvalid);
        resp         = (st == X_READ) ? rresp : bresp;
        tmo_hit      = (st != X_IDLE) && !resp_hit && (cnt == CNT_LAST);
        done.valid   = resp_hit || tmo_hit;
        done.res     = tmo_hit ? RES_TMO : (resp[1] ? RES_ERR : RES_OK);
        done.is_read = (st == X_READ);
        done.rdata   = rdata;
    end

    assign busy    = (st != X_IDLE);
    assign awaddr  = addr_q;
    assign araddr  = addr_q;
    assign wdata   = wdata_q;
    assign wstrb   = '1;
    assign awvalid = (st == X_WRITE) && !aw_done;
    assign wvalid  = (st == X_WRITE) && !w_done;
    assign bready  = (st == X_WRITE);
    assign arvalid = (st == X_READ) && !ar_done;
    assign rready  = (st == X_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= X_IDLE;
            aw_done <= 1'b0;
            w_done  <= 1'b0;
            ar_done <= 1'b0;
            cnt     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (st == X_IDLE) begin
            if (req.go) begin
                st      <= req.is_read ? X_READ : X_WRITE;
                addr_q  <= req.addr;
                wdata_q <= req.wdata;
                aw_done <= 1'b0;
                w_done  <= 1'b0;
                ar_done <= 1'b0;
                cnt     <= '0;
            end
        end else if (done.valid) begin
            st <= X_IDLE;
        end else begin
            cnt <= cnt + 1'b1;
            if (awvalid && awready) aw_done <= 1'b1;
            if (wvalid && wready)   w_done  <= 1'b1;
            if (arvalid && arready) ar_done <= 1'b1;
        end
    end

    // R2: write address held until accepted unless the transfer ends
    p_aw_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (awvalid && !awready && !done.valid) |=> awvalid);

    // R9: no request channel is active while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(awvalid || wvalid || arvalid || bready || rready));

    // R8: the watchdog never passes its limit
    p_tmo_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(TMO_CYCLES));

    // R12: one outcome per transaction, then idle
    p_single_outcome_r12: assert property (@(posedge clk) disable iff (rst)
        done.valid |=> (!done.valid && !busy));

endmodule

// File: rtl/axlb_regs.sv
module axlb_regs
    import axlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RA_W-1:0] hst_addr,
    input  logic [HW-1:0]   hst_wdata,
    input  logic            hst_wr,
    output logic [HW-1:0]   hst_rdata,
    input  logic            axi_irq_i,
    output logic            irq_o,
    input  logic            busy,
    input  done_t           done,
    output req_t            req
);

    logic [NEV-1:0] ev, en, raw, set_m, clr_m;
    logic [HW-1:0]  alo, ahi, wlo, whi, rlo, rhi;
    logic           avail, init_q, inc_q;
    logic           wr_stat, wr_ctrl, start, data_wr_ok, ok_done;
    logic [AW-1:0]  addr_next;

    always_comb begin
        wr_stat    = hst_wr && (hst_addr == OFS_STAT);
        wr_ctrl    = hst_wr && (hst_addr == OFS_CTRL);
        start      = wr_ctrl && !busy && cmd_is_xfer(hst_wdata[3:0]);
        data_wr_ok = hst_wr && !busy;
        ok_done    = done.valid && (done.res == RES_OK);
        raw = '0;
        if (done.valid) begin
            unique case (done.res)
                RES_OK:  raw[done.is_read ? EV_RD : EV_WR] = 1'b1;
                RES_ERR: raw[EV_ERR] = 1'b1;
                default: raw[EV_TMO] = 1'b1;
            endcase
        end
        raw[EV_IRQ] = axi_irq_i;
        set_m     = raw & en;
        clr_m     = wr_stat ? hst_wdata[HW-1 -: NEV] : '0;
        addr_next = {ahi, alo} + ADDR_STEP;
    end

    assign req.go      = start;
    assign req.is_read = hst_wdata[1];
    assign req.addr    = {ahi, alo};
    assign req.wdata   = {whi, wlo};
    assign irq_o       = |(ev & en);

    always_comb begin
        unique case (hst_addr)
            OFS_STAT: hst_rdata = status_word(ev, avail, busy, init_q);
            OFS_CTRL: hst_rdata = {en, {(HW-NEV){1'b0}}};
            OFS_ALO:  hst_rdata = alo;
            OFS_AHI:  hst_rdata = ahi;
            OFS_WLO:  hst_rdata = wlo;
            OFS_WHI:  hst_rdata = whi;
            OFS_RLO:  hst_rdata = rlo;
            default:  hst_rdata = rhi;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev <= '0; en <= '0;
            alo <= '0; ahi <= '0; wlo <= '0; whi <= '0; rlo <= '0; rhi <= '0;
            avail <= 1'b0; init_q <= 1'b0; inc_q <= 1'b0;
        end else begin
            init_q <= 1'b1;
            ev     <= (ev & ~clr_m) | set_m;
            if (wr_ctrl) en <= hst_wdata[HW-1 -: NEV];
            if (start) begin
                inc_q <= hst_wdata[0];
                avail <= 1'b0;
            end
            if (ok_done && done.is_read) begin
                {rhi, rlo} <= done.rdata;
                avail      <= 1'b1;
            end
            if (ok_done && inc_q) begin
                {ahi, alo} <= addr_next;
            end else if (data_wr_ok) begin
                unique case (hst_addr)
                    OFS_ALO: alo <= hst_wdata;
                    OFS_AHI: ahi <= hst_wdata;
                    OFS_WLO: wlo <= hst_wdata;
                    OFS_WHI: whi <= hst_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R7: read data available only follows a successful read
    p_avail_src_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(avail) |-> $past(done.valid && done.res == RES_OK && done.is_read));

    // R9: address writes while busy have no effect
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && hst_wr && hst_addr == OFS_ALO && !done.valid) |=> $stable(alo));

    // R6: post-increment adds one word with carry
    p_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (ok_done && inc_q) |=> ({ahi, alo} == $past({ahi, alo}) + ADDR_STEP));

    // R4: a write-complete flag only rises with its enable set
    p_stat_gate_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ev[EV_WR]) |-> $past(en[EV_WR]));

endmodule

// File: rtl/axlb_bridge.sv
module axlb_bridge
    import axlb_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  hst_addr,
    input  logic [15:0] hst_wdata,
    input  logic        hst_wr,
    output logic [15:0] hst_rdata,
    input  logic        axi_irq_i,
    output logic        irq_o,
    output logic [31:0] m_awaddr,
    output logic        m_awvalid,
    input  logic        m_awready,
    output logic [31:0] m_wdata,
    output logic [3:0]  m_wstrb,
    output logic        m_wvalid,
    input  logic        m_wready,
    input  logic [1:0]  m_bresp,
    input  logic        m_bvalid,
    output logic        m_bready,
    output logic [31:0] m_araddr,
    output logic        m_arvalid,
    input  logic        m_arready,
    input  logic [31:0] m_rdata,
    input  logic [1:0]  m_rresp,
    input  logic        m_rvalid,
    output logic        m_rready
);

    req_t  req;
    done_t done;
    logic  busy;

    axlb_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .hst_addr  (hst_addr),
        .hst_wdata (hst_wdata),
        .hst_wr    (hst_wr),
        .hst_rdata (hst_rdata),
        .axi_irq_i (axi_irq_i),
        .irq_o     (irq_o),
        .busy      (busy),
        .done      (done),
        .req       (req)
    );

    axlb_xfer #(.TMO_CYCLES(TMO_CYCLES)) u_xfer (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .done    (done),
        .busy    (busy),
        .awaddr  (m_awaddr),
        .awvalid (m_awvalid),
        .awready (m_awready),
        .wdata   (m_wdata),
        .wstrb   (m_wstrb),
        .wvalid  (m_wvalid),
        .wready  (m_wready),
        .bresp   (m_bresp),
        .bvalid  (m_bvalid),
        .bready  (m_bready),
        .araddr  (m_araddr),
        .arvalid (m_arvalid),
        .arready (m_arready),
        .rdata   (m_rdata),
        .rresp   (m_rresp),
        .rvalid  (m_rvalid),
        .rready  (m_rready)
    );

endmodule

// File: tb/axlb_bridge_bench.sv
module axlb_bridge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic        hst_wr = 1'b0;
    logic [15:0] hst_rdata;
    logic        axi_irq_i = 1'b0;
    logic        irq_o;
    logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
    logic [3:0]  m_wstrb;
    logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
    logic        m_bvalid, m_rvalid;
    logic [1:0]  m_bresp, m_rresp;

    always #4 clk = ~clk;

    axlb_bridge u_axlb_bridge (
        .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_wr(hst_wr), .hst_rdata(hst_rdata), .axi_irq_i(axi_irq_i), .irq_o(irq_o),
        .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(1'b1),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(1'b1),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(1'b1),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
    );

    // ---------------- AXI slave model ----------------
    logic        mute = 1'b0;
    logic [7:0]  lat = 8'd0;
    logic [1:0]  resp_sel = 2'd0;
    logic [31:0] mem [16];
    logic [31:0] last_aw, last_w, last_ar;
    logic [3:0]  last_s;
    int          wr_cnt, rd_cnt;
    logic        bpend, rpend;
    logic [7:0]  bwait, rwait;
    logic [3:0]  ridx;

    always @(posedge clk) begin
        if (rst) begin
            m_bvalid <= 1'b0; m_rvalid <= 1'b0; bpend <= 1'b0; rpend <= 1'b0;
            wr_cnt <= 0; rd_cnt <= 0; m_bresp <= '0; m_rresp <= '0; m_rdata <= '0;
            last_aw <= '0; last_w <= '0; last_ar <= '0; last_s <= '0;
        end else begin
            if (m_awvalid && m_wvalid) begin
                mem[m_awaddr[5:2]] <= m_wdata;
                last_aw <= m_awaddr; last_w <= m_wdata; last_s <= m_wstrb;
                wr_cnt <= wr_cnt + 1;
                if (!mute) begin bpend <= 1'b1; bwait <= lat; end
            end
            if (bpend) begin
                if (bwait == 0) begin m_bvalid <= 1'b1; m_bresp <= resp_sel; bpend <= 1'b0; end
                else bwait <= bwait - 1;
            end
            if (m_bvalid && m_bready) m_bvalid <= 1'b0;
            if (m_arvalid) begin
                last_ar <= m_araddr; ridx <= m_araddr[5:2];
                rd_cnt <= rd_cnt + 1;
                if (!mute) begin rpend <= 1'b1; rwait <= lat; end
            end
            if (rpend) begin
                if (rwait == 0) begin
                    m_rvalid <= 1'b1; m_rdata <= mem[ridx]; m_rresp <= resp_sel; rpend <= 1'b0;
                end else rwait <= rwait - 1;
            end
            if (m_rvalid && m_rready) m_rvalid <= 1'b0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [7:0]  rq;
        logic [2:0]  ofs;
        logic [15:0] val;
    } exp_t;

    exp_t expq[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    logic finished = 1'b0;

    task automatic hwrite(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        hst_addr = a;
        #1 d = hst_rdata;
    endtask

    task automatic expect_reg(input int rq, input logic [2:0] a, input logic [15:0] v);
        expq.push_back('{rq: 8'(rq), ofs: a, val: v});
    endtask

    // monitor: pops expectations and compares against host reads
    task automatic drain();
        logic [15:0] got;
        while (expq.size() > 0) begin
            exp_t e = expq.pop_front();
            hread(e.ofs, got);
            n_tests++;
            if (got !== e.val) begin
                n_fail++;
                $display("FAIL R%0d reg %0d: got %h expected %h", e.rq, e.ofs, got, e.val);
            end
        end
    endtask

    task automatic chk(input int rq, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 300; i++) begin
            hread(3'd0, s);
            if (!s[6]) break;
        end
    endtask

    task automatic set_addr(input logic [31:0] a);
        hwrite(3'd2, a[15:0]);
        hwrite(3'd3, a[31:16]);
    endtask

    task automatic set_wdata(input logic [31:0] d);
        hwrite(3'd4, d[15:0]);
        hwrite(3'd5, d[31:16]);
    endtask

    initial begin
        logic [15:0] s;
        int w0, r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_reg(1, 3'd0, 16'h0020);
        for (int k = 1; k < 8; k++) expect_reg(1, 3'(k), 16'h0000);
        drain();
        chk(1, "irq after reset", 32'(irq_o), 32'd0);
        chk(1, "valids after reset", {29'd0, m_awvalid, m_wvalid, m_arvalid}, 32'd0);

        // R11 NOP and an unlisted code
        hwrite(3'd1, 16'hF800);
        hwrite(3'd1, 16'hF804);
        repeat (3) @(negedge clk);
        chk(11, "no transfer for NOP", 32'(wr_cnt + rd_cnt), 32'd0);
        expect_reg(11, 3'd0, 16'h0020);
        expect_reg(11, 3'd1, 16'hF800);
        drain();

        // R2 write
        set_addr(32'h0000_0010);
        set_wdata(32'hDEAD_BEEF);
        hwrite(3'd1, 16'hF808);
        wait_idle();
        chk(2, "awaddr", last_aw, 32'h10);
        chk(2, "wdata", last_w, 32'hDEAD_BEEF);
        chk(2, "wstrb", 32'(last_s), 32'hF);
        expect_reg(2, 3'd0, 16'h4020);
        expect_reg(2, 3'd2, 16'h0010);
        drain();
        chk(10, "irq on write complete", 32'(irq_o), 32'd1);

        // R5 W1C: zero leaves bit, one clears it
        hwrite(3'd0, 16'h0000);
        expect_reg(5, 3'd0, 16'h4020);
        drain();
        hwrite(3'd0, 16'h40E0);
        expect_reg(5, 3'd0, 16'h0020);
        drain();
        chk(5, "irq after clear", 32'(irq_o), 32'd0);

        // R3 read
        hwrite(3'd1, 16'hF80A);
        wait_idle();
        chk(3, "araddr", last_ar, 32'h10);
        expect_reg(3, 3'd0, 16'h80A0);
        expect_reg(3, 3'd6, 16'hBEEF);
        expect_reg(3, 3'd7, 16'hDEAD);
        drain();
        hwrite(3'd0, 16'h8000);
        expect_reg(5, 3'd0, 16'h00A0);
        drain();

        // R6 post-increment with carry, write then read
        set_addr(32'h0001_FFFC);
        set_wdata(32'h1234_5678);
        hwrite(3'd1, 16'hF809);
        wait_idle();
        chk(6, "awaddr before inc", last_aw, 32'h0001_FFFC);
        expect_reg(6, 3'd2, 16'h0000);
        expect_reg(6, 3'd3, 16'h0002);
        expect_reg(3, 3'd0, 16'h4020);    // R3: bit 7 cleared by new command
        drain();
        hwrite(3'd0, 16'hF800);
        set_addr(32'h0001_FFFC);
        hwrite(3'd1, 16'hF80B);
        wait_idle();
        expect_reg(6, 3'd6, 16'h5678);
        expect_reg(6, 3'd7, 16'h1234);
        expect_reg(6, 3'd2, 16'h0000);
        expect_reg(6, 3'd3, 16'h0002);
        drain();
        hwrite(3'd0, 16'hF800);

        // R4 enable gating: write complete disabled
        hwrite(3'd1, 16'hB808);
        wait_idle();
        expect_reg(4, 3'd0, 16'h0020);
        drain();
        chk(4, "irq with event disabled", 32'(irq_o), 32'd0);

        // R7 error responses
        hwrite(3'd1, 16'hF800);
        resp_sel = 2'd2;
        set_addr(32'h0000_0040);
        hwrite(3'd1, 16'hF80B);
        wait_idle();
        expect_reg(7, 3'd0, 16'h1020);
        expect_reg(7, 3'd2, 16'h0040);
        expect_reg(7, 3'd6, 16'h5678);
        expect_reg(7, 3'd7, 16'h1234);
        drain();
        hwrite(3'd0, 16'hF800);
        resp_sel = 2'd3;
        hwrite(3'd1, 16'hF809);
        wait_idle();
        expect_reg(7, 3'd0, 16'h1020);
        expect_reg(7, 3'd2, 16'h0040);
        drain();
        hwrite(3'd0, 16'hF800);
        resp_sel = 2'd0;

        // R9 busy and ignored commands
        lat = 8'd20;
        w0 = wr_cnt; r0 = rd_cnt;
        hwrite(3'd1, 16'hF808);
        expect_reg(9, 3'd0, 16'h0060);
        drain();
        hwrite(3'd2, 16'h0099);
        hwrite(3'd1, 16'hF00A);
        expect_reg(9, 3'd1, 16'hF000);   // enables still writable
        drain();
        wait_idle();
        hwrite(3'd1, 16'hF800);
        chk(9, "one write only", 32'(wr_cnt - w0), 32'd1);
        chk(9, "no read started", 32'(rd_cnt - r0), 32'd0);
        expect_reg(9, 3'd2, 16'h0040);
        expect_reg(9, 3'd0, 16'h4020);
        drain();
        hwrite(3'd0, 16'hF800);
        lat = 8'd0;

        // R8 timeout
        mute = 1'b1;
        hwrite(3'd1, 16'hF80A);
        repeat (40) @(negedge clk);
        expect_reg(8, 3'd0, 16'h0060);
        drain();
        repeat (40) @(negedge clk);
        expect_reg(8, 3'd0, 16'h2020);
        drain();
        chk(8, "ready/valid after timeout", {30'd0, m_arvalid, m_rready}, 32'd0);
        chk(10, "irq on timeout", 32'(irq_o), 32'd1);
        hwrite(3'd0, 16'hF800);
        mute = 1'b0;

        // R10 AXI interrupt input and enable masking
        @(negedge clk); axi_irq_i = 1'b1;
        @(negedge clk); axi_irq_i = 1'b0;
        expect_reg(10, 3'd0, 16'h0820);
        drain();
        chk(10, "irq from axi int", 32'(irq_o), 32'd1);
        hwrite(3'd1, 16'hF000);
        chk(10, "irq masked by enable", 32'(irq_o), 32'd0);
        expect_reg(10, 3'd0, 16'h0820);
        drain();
        hwrite(3'd0, 16'h0800);
        @(negedge clk); axi_irq_i = 1'b1;
        @(negedge clk); axi_irq_i = 1'b0;
        expect_reg(4, 3'd0, 16'h0020);
        drain();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule